// File: doc/BRIEF.md
# Link Wake Request Generator

This block sits in a serial-bus physical layer and decides when to wake the attached link-layer controller. It drives one shared pin that does two jobs. During hardware reset the block does not drive the pin, and it latches the level on the pin as the default bus-manager contender bit. After reset the block drives the pin. The pin carries a fixed-period square wave while a wake request is pending, and it is held low otherwise.

A wake request can start only while the link is inactive. The link is inactive when its power status is low or its control bit is clear. There are two kinds of cause:

- **Packet cause.** A received link-on packet addressed to this node starts a request. A later bus reset cancels a request that rests only on this cause.
- **Interrupt cause.** The port-event interrupt bit starts a request. Any of the three timeout or cable-power interrupt bits also starts one, but only while the resuming-port enable is set. An interrupt cause survives a bus reset.

Once started, a request lasts until the link becomes active. It does not end when its cause is removed.

Top module: `lkon_wake_gen`

## Requirements
- R1: While `hw_rst` is high, `pin_oe` is low, and `pin_out` is low after every clock edge.
- R2: `contender` takes the value of `pin_in` at each clock edge while `hw_rst` is high (1 means contender). After reset it holds that value and ignores `pin_in` until the next hardware reset.
- R3: While `hw_rst` is low, `pin_oe` is high.
- R4: With no wake request pending, `pin_out` is low.
- R5: While a request is pending, `pin_out` repeats 4 clocks high and then 4 clocks low. The first clock after the request starts is the first of a full high phase.
- R6: The link is active only when both `link_pwr` and `link_ctl` are 1. A clock edge that sees the link active ends any request, so `pin_out` is low after it.
- R7: A `lkon_pkt` pulse seen while the link is inactive starts a request at that clock edge. A pulse seen while the link is active is ignored.
- R8: `irq_port_evt` = 1 with the link inactive starts a request, whatever the value of `irq_resume_en`.
- R9: `irq_cfg_to`, `irq_cpwr` or `irq_state_to` starts a request only when `irq_resume_en` is 1 and the link is inactive.
- R10: A pending request stays pending after its cause is removed, until the link becomes active.
- R11: A `bus_rst` pulse with no interrupt cause present ends the request. A `bus_rst` pulse in the same cycle as `lkon_pkt` leaves no request.
- R12: A `bus_rst` pulse while an interrupt cause is present leaves the request pending.
- R13: An interrupt cause already present while the link is active starts a request at the first clock edge that sees the link inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| hw_rst | input | 1 | Hardware reset, active high, synchronous |
| link_pwr | input | 1 | Link power status, 1 = powered |
| link_ctl | input | 1 | Link-control bit |
| lkon_pkt | input | 1 | One-cycle pulse: link-on packet for this node received |
| bus_rst | input | 1 | One-cycle pulse: bus reset occurred |
| irq_port_evt | input | 1 | Port-event interrupt bit |
| irq_cfg_to | input | 1 | Configuration-timeout interrupt bit |
| irq_cpwr | input | 1 | Cable-power-status interrupt bit |
| irq_state_to | input | 1 | State-timeout interrupt bit |
| irq_resume_en | input | 1 | Resuming-port interrupt enable |
| pin_in | input | 1 | Level seen on the shared pin |
| pin_out | output | 1 | Drive value for the shared pin |
| pin_oe | output | 1 | Output enable for the shared pin |
| contender | output | 1 | Latched default contender bit |

## Verification
The bench goes after these corner cases:

- **Bus reset in the same cycle as a packet.** A design that lets the packet win would leave a wake running that the bus reset should have cancelled.
- **Bus reset while an interrupt is still set.** A design that clears on every bus reset would drop a wake that must survive.
- **Interrupt raised while the link is active.** The bench then drops the link. A design that latches only on the rising edge of the interrupt would never wake.
- **Square-wave phase.** The bench checks the phase of the wave, so a counter that is not restarted gives a short first high phase.
- **Contender after reset.** The bench toggles `pin_in` after reset, so a contender latch that keeps sampling would track the pin.

// File: rtl/lkon_wake_gen.sv
module lkon_wake_gen #(
  parameter int PERIOD = 8
) (
  input  logic clk,
  input  logic hw_rst,
  input  logic link_pwr,
  input  logic link_ctl,
  input  logic lkon_pkt,
  input  logic bus_rst,
  input  logic irq_port_evt,
  input  logic irq_cfg_to,
  input  logic irq_cpwr,
  input  logic irq_state_to,
  input  logic irq_resume_en,
  input  logic pin_in,
  output logic pin_out,
  output logic pin_oe,
  output logic contender
);
  localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] HALF = CW'(PERIOD / 2);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic          wake_on;
  logic [CW-1:0] phase;
  logic          link_up;
  logic          irq_cause;
  logic          wake_nxt;

  assign link_up   = link_pwr & link_ctl;
  assign irq_cause = irq_port_evt | (irq_resume_en & (irq_cfg_to | irq_cpwr | irq_state_to));
  assign wake_nxt  = ~link_up & (irq_cause | (~bus_rst & (wake_on | lkon_pkt)));

  always_ff @(posedge clk) begin
    if (hw_rst) begin
      wake_on   <= 1'b0;
      phase     <= '0;
      contender <= pin_in;
    end else begin
      wake_on <= wake_nxt;
      if (!wake_on || phase == LAST) phase <= '0;
      else                           phase <= phase + 1'b1;
    end
  end

  assign pin_oe  = ~hw_rst;
  assign pin_out = wake_on & (phase < HALF);

  // R1
  rst_quiet_chk: assert property (@(posedge clk) hw_rst |=> !pin_out);

  // R2
  contender_hold_chk: assert property (@(posedge clk) disable iff (hw_rst)
    !$past(hw_rst) |-> $stable(contender));

  // R6
  link_up_ends_chk: assert property (@(posedge clk) disable iff (hw_rst)
    link_up |=> !pin_out);

  // R13
  irq_wakes_chk: assert property (@(posedge clk) disable iff (hw_rst)
    (!link_up && irq_cause) |=> wake_on);

  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (hw_rst)
    (wake_on && !link_up && !bus_rst) |=> wake_on);

  // R5
  first_high_chk: assert property (@(posedge clk) disable iff (hw_rst)
    $rose(wake_on) |-> pin_out);
endmodule

// File: tb/lkon_wake_gen_tb.sv
module lkon_wake_gen_tb_top;
  logic clk = 1'b0;
  logic hw_rst, link_pwr, link_ctl, lkon_pkt, bus_rst;
  logic irq_port_evt, irq_cfg_to, irq_cpwr, irq_state_to, irq_resume_en, pin_in;
  wire  pin_out, pin_oe, contender;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string cur_req = "R4";
  bit m_on = 0, m_cont = 0;
  int m_ph = 0;

  always #10 clk = ~clk;

  lkon_wake_gen dut_i (
    .clk(clk), .hw_rst(hw_rst), .link_pwr(link_pwr), .link_ctl(link_ctl),
    .lkon_pkt(lkon_pkt), .bus_rst(bus_rst), .irq_port_evt(irq_port_evt),
    .irq_cfg_to(irq_cfg_to), .irq_cpwr(irq_cpwr), .irq_state_to(irq_state_to),
    .irq_resume_en(irq_resume_en), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .contender(contender)
  );

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step();
    bit la, ic;
    int nph;
    @(posedge clk);
    la  = link_pwr && link_ctl;
    ic  = irq_port_evt || (irq_resume_en && (irq_cfg_to || irq_cpwr || irq_state_to));
    nph = m_on ? (m_ph + 1) % 8 : 0;
    if (hw_rst) begin
      m_on = 0; nph = 0; m_cont = pin_in;
    end else if (la)   m_on = 0;
    else if (ic)       m_on = 1;
    else if (bus_rst)  m_on = 0;
    else if (lkon_pkt) m_on = 1;
    m_ph = nph;
    @(negedge clk);
    chk(pin_out, m_on && m_ph < 4, cur_req, "pin_out vs model");
    chk(pin_oe, !hw_rst, "R3", "pin_oe vs model");
    chk(contender, m_cont, "R2", "contender vs model");
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic pulse_pkt();
    lkon_pkt = 1; step(); lkon_pkt = 0;
  endtask

  task automatic pulse_brst();
    bus_rst = 1; step(); bus_rst = 0;
  endtask

  task automatic expect_wake(input bit exp, input string req);
    int highs = 0;
    for (int i = 0; i < 8; i++) begin
      step();
      if (pin_out === 1'b1) highs++;
    end
    chk(highs == (exp ? 4 : 0), 1'b1, req, $sformatf("high count %0d over 8 cycles", highs));
  endtask

  initial begin
    hw_rst = 1; link_pwr = 0; link_ctl = 0; lkon_pkt = 0; bus_rst = 0;
    irq_port_evt = 0; irq_cfg_to = 0; irq_cpwr = 0; irq_state_to = 0;
    irq_resume_en = 0; pin_in = 1;

    // R1 R2: reset, pin strapped high
    cur_req = "R1";
    steps(3);
    chk(pin_oe, 1'b0, "R1", "oe during reset");
    chk(pin_out, 1'b0, "R1", "out during reset");
    hw_rst = 0;
    cur_req = "R4";
    step();
    chk(pin_oe, 1'b1, "R3", "oe after reset");
    chk(contender, 1'b1, "R2", "contender latched high");
    pin_in = 0;
    steps(3);
    chk(contender, 1'b1, "R2", "contender ignores pin after reset");
    expect_wake(0, "R4");

    // R7: packet ignored while link active
    link_pwr = 1; link_ctl = 1;
    cur_req = "R7";
    pulse_pkt();
    expect_wake(0, "R7");

    // R7 R5: packet with link inactive (ctl clear)
    link_ctl = 0;
    step();
    pulse_pkt();
    chk(pin_out, 1'b1, "R5", "first cycle of wake is high");
    cur_req = "R5";
    expect_wake(1, "R7");
    steps(8);

    // R6: link becomes active ends the wake
    link_ctl = 1;
    cur_req = "R6";
    step();
    chk(pin_out, 1'b0, "R6", "wake ended by link active");
    expect_wake(0, "R6");

    // R11: bus reset clears packet-only wake
    link_pwr = 0;
    cur_req = "R11";
    pulse_pkt();
    steps(3);
    pulse_brst();
    chk(pin_out, 1'b0, "R11", "bus reset cleared packet wake");
    expect_wake(0, "R11");
    lkon_pkt = 1; bus_rst = 1; step(); lkon_pkt = 0; bus_rst = 0;
    expect_wake(0, "R11");

    // R9: gated interrupts need enable
    cur_req = "R9";
    irq_cfg_to = 1;
    expect_wake(0, "R9");
    irq_cfg_to = 0; irq_state_to = 1;
    expect_wake(0, "R9");
    irq_resume_en = 1;
    expect_wake(1, "R9");

    // R10: cause removed, wake continues
    irq_state_to = 0; irq_resume_en = 0;
    cur_req = "R10";
    expect_wake(1, "R10");

    // R12: bus reset with interrupt present keeps wake
    irq_port_evt = 1;
    cur_req = "R12";
    pulse_brst();
    expect_wake(1, "R12");
    irq_port_evt = 0;
    pulse_brst();
    expect_wake(0, "R11");

    // R8: port event without enable
    cur_req = "R8";
    irq_port_evt = 1;
    expect_wake(1, "R8");
    irq_port_evt = 0;

    // R13: pending interrupt while link active
    link_pwr = 1; link_ctl = 1;
    irq_cpwr = 1; irq_resume_en = 1;
    cur_req = "R13";
    expect_wake(0, "R13");
    link_pwr = 0;
    step();
    chk(pin_out, 1'b1, "R13", "wake at first inactive edge");
    expect_wake(1, "R13");
    irq_cpwr = 0; irq_resume_en = 0;

    // R2: second reset with pin low
    hw_rst = 1; pin_in = 0;
    cur_req = "R1";
    steps(2);
    chk(pin_oe, 1'b0, "R1", "oe in second reset");
    hw_rst = 0; pin_in = 1;
    cur_req = "R4";
    step();
    chk(contender, 1'b0, "R2", "contender relatched low");
    expect_wake(0, "R4");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule